// File: doc/BRIEF.md
# Conversion Result Window Monitor

This block sits beside an analog-to-digital converter and inspects every finished conversion result. A result whose raw 12-bit value lies outside a programmable window sets a sticky event flag. The window has an inclusive low bound and an inclusive high bound. The event flag can be routed to an interrupt line through an enable. Each result arrives with its channel number and a group tag: regular group or inserted group. The tag lets monitoring be limited to the groups of interest, or narrowed to one selected channel.

Results enter on a valid/ready stream. The monitor never back-pressures: `res_ready` is high whenever the block is out of reset, so every cycle with `res_valid` high delivers one result. The producer may keep `res_valid` high on consecutive cycles. Data on a cycle with `res_valid` low carries no meaning.

The monitoring configuration is held in a register. A `cfg_wr` pulse loads it and a `cfg_off` pulse disables monitoring. The interrupt enable and the flag clear are plain level inputs.

Top module: `awd_window_monitor`

## Requirements
- R1: After reset, `evt_flag` and `evt_irq` are 0, both group enables and single-channel mode are off, and the thresholds are 0.
- R2: A monitored result raises an event when its value is strictly above the high threshold or strictly below the low threshold. A value equal to either threshold raises no event. Thresholds span 0 to 4095. The comparison uses the raw, unshifted value.
- R3: In group mode (`cfg_single`=0), `res_grp`=0 marks a regular result and `res_grp`=1 marks an inserted result. A result is monitored only if its group's enable (`cfg_reg_en` or `cfg_ins_en`) is set, and any channel of that group is compared.
- R4: In single-channel mode (`cfg_single`=1), results of both groups are monitored whatever the group enables say. Only a result with `res_chan` equal to the selected channel is compared.
- R5: A `cfg_off` pulse clears both group enables, single-channel mode and the channel selection, and leaves the thresholds unchanged. When `cfg_off` and `cfg_wr` are high together, `cfg_off` wins.
- R6: `evt_flag` goes to 1 one clock after an event and stays at 1 until `evt_clr` is sampled high. An event in the same cycle as `evt_clr` leaves the flag set.
- R7: `evt_irq` is 1 exactly while `evt_flag` and `int_en` are both 1.
- R8: `res_ready` is 1 out of reset. A cycle with `res_valid` low never raises an event.
- R9: A configuration loaded by `cfg_wr` governs results accepted on the clock edges after the load edge. A result accepted on the load edge itself is judged by the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready (always 1 out of reset) |
| res_data | input | 12 | Raw conversion value |
| res_chan | input | 5 | Channel that produced the value |
| res_grp | input | 1 | 0 regular group, 1 inserted group |
| cfg_wr | input | 1 | Load configuration fields |
| cfg_off | input | 1 | Disable monitoring |
| cfg_lo | input | 12 | Low threshold |
| cfg_hi | input | 12 | High threshold |
| cfg_single | input | 1 | Single-channel mode |
| cfg_chan | input | 5 | Selected channel |
| cfg_reg_en | input | 1 | Regular group enable |
| cfg_ins_en | input | 1 | Inserted group enable |
| int_en | input | 1 | Interrupt enable |
| evt_clr | input | 1 | Clear event flag |
| evt_flag | output | 1 | Sticky out-of-window flag |
| evt_irq | output | 1 | Gated interrupt |

## Verification
Values placed at, just inside and just outside each threshold separate strict from inclusive comparison and show which bound is being compared. Results with the group tag flipped, and with the channel matching or not matching the selection, separate group mode from single-channel mode. A disable pulse followed by out-of-window values shows that the enables are cleared. A same-cycle clear and event shows the set-over-clear priority. A long stretch of random configurations, results, clears and interrupt-enable levels is compared cycle by cycle with a reference model, which catches ordering errors between configuration loads and results.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int AWD_DATA_W = 12;
  localparam int AWD_CH_W   = 5;

  typedef enum logic {
    GRP_REGULAR  = 1'b0,
    GRP_INSERTED = 1'b1
  } awd_grp_e;
endpackage

// File: rtl/awd_cfg_reg.sv
module awd_cfg_reg #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              off,
  input  logic [DATA_W-1:0] lo_in,
  input  logic [DATA_W-1:0] hi_in,
  input  logic              single_in,
  input  logic [CH_W-1:0]   chan_in,
  input  logic              reg_en_in,
  input  logic              ins_en_in,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q,
  output logic              single_q,
  output logic [CH_W-1:0]   chan_q,
  output logic              reg_en_q,
  output logic              ins_en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      single_q <= 1'b0;
      chan_q   <= '0;
      reg_en_q <= 1'b0;
      ins_en_q <= 1'b0;
    end else if (off) begin
      single_q <= 1'b0;
      chan_q   <= '0;
      reg_en_q <= 1'b0;
      ins_en_q <= 1'b0;
    end else if (wr) begin
      lo_q     <= lo_in;
      hi_q     <= hi_in;
      single_q <= single_in;
      chan_q   <= chan_in;
      reg_en_q <= reg_en_in;
      ins_en_q <= ins_en_in;
    end
  end

  // R5: a disable pulse leaves every mode bit cleared on the next cycle
  assert_off_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (!single_q && !reg_en_q && !ins_en_q && chan_q == '0));

  // R5: thresholds survive a disable pulse
  assert_off_keeps_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/awd_cmp.sv
module awd_cmp #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 5
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic [CH_W-1:0]   chan,
  input  logic              grp,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic              single,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic              reg_en,
  input  logic              ins_en,
  output logic              hit
);
  import awd_pkg::*;

  logic watched;
  logic outside;

  always_comb begin
    if (single) begin
      watched = (chan == sel_chan);
    end else begin
      unique case (awd_grp_e'(grp))
        GRP_REGULAR:  watched = reg_en;
        GRP_INSERTED: watched = ins_en;
        default:      watched = 1'b0;
      endcase
    end
    outside = (data > hi) || (data < lo);
    hit     = valid && watched && outside;
  end

  // R8: no event can come from an idle stream cycle
  always_comb begin
    assert_hit_needs_valid_R8: assert (!hit || valid);
  end
endmodule

// File: rtl/awd_flag.sv
module awd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic int_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag & int_en;

  // R6: without a clear the flag never drops
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R6: an event wins over a clear in the same cycle
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R7: the interrupt never fires without a pending flag
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

// File: rtl/awd_window_monitor.sv
module awd_window_monitor #(
  parameter int DATA_W = awd_pkg::AWD_DATA_W,
  parameter int CH_W   = awd_pkg::AWD_CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CH_W-1:0]   res_chan,
  input  logic              res_grp,
  input  logic              cfg_wr,
  input  logic              cfg_off,
  input  logic [DATA_W-1:0] cfg_lo,
  input  logic [DATA_W-1:0] cfg_hi,
  input  logic              cfg_single,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_reg_en,
  input  logic              cfg_ins_en,
  input  logic              int_en,
  input  logic              evt_clr,
  output logic              evt_flag,
  output logic              evt_irq
);
  logic [DATA_W-1:0] lo_q, hi_q;
  logic              single_q, reg_en_q, ins_en_q;
  logic [CH_W-1:0]   chan_q;
  logic              hit;

  assign res_ready = rst_n;

  awd_cfg_reg #(.DATA_W(DATA_W), .CH_W(CH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .off(cfg_off),
    .lo_in(cfg_lo), .hi_in(cfg_hi), .single_in(cfg_single),
    .chan_in(cfg_chan), .reg_en_in(cfg_reg_en), .ins_en_in(cfg_ins_en),
    .lo_q(lo_q), .hi_q(hi_q), .single_q(single_q), .chan_q(chan_q),
    .reg_en_q(reg_en_q), .ins_en_q(ins_en_q)
  );

  awd_cmp #(.DATA_W(DATA_W), .CH_W(CH_W)) u_cmp (
    .valid(res_valid), .data(res_data), .chan(res_chan), .grp(res_grp),
    .lo(lo_q), .hi(hi_q), .single(single_q), .sel_chan(chan_q),
    .reg_en(reg_en_q), .ins_en(ins_en_q), .hit(hit)
  );

  awd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(evt_clr),
    .int_en(int_en), .flag(evt_flag), .irq(evt_irq)
  );

  // R8: an idle stream cycle cannot set a clear flag
  assert_idle_no_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !evt_flag) |=> !evt_flag);

  // R8: the stream is accepted whenever out of reset
  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_ready);
endmodule

// File: tb/tb_awd_window_monitor.sv
module tb_awd_window_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 0, res_grp = 0, cfg_wr = 0, cfg_off = 0, cfg_single = 0;
  logic cfg_reg_en = 0, cfg_ins_en = 0, int_en = 0, evt_clr = 0;
  logic [11:0] res_data = 0, cfg_lo = 0, cfg_hi = 0;
  logic [4:0]  res_chan = 0, cfg_chan = 0;
  logic res_ready, evt_flag, evt_irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference model state
  logic [11:0] m_lo = 0, m_hi = 0;
  logic [4:0]  m_chan = 0;
  logic m_single = 0, m_reg = 0, m_ins = 0, m_flag = 0;

  always #5 clk = ~clk;

  awd_window_monitor dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_chan(res_chan), .res_grp(res_grp),
    .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_single(cfg_single), .cfg_chan(cfg_chan), .cfg_reg_en(cfg_reg_en),
    .cfg_ins_en(cfg_ins_en), .int_en(int_en), .evt_clr(evt_clr),
    .evt_flag(evt_flag), .evt_irq(evt_irq)
  );

  function automatic logic exp_hit(logic v, logic [11:0] d, logic [4:0] c, logic g);
    logic w;
    if (m_single) w = (c == m_chan);
    else          w = g ? m_ins : m_reg;
    return v && w && ((d > m_hi) || (d < m_lo));
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at t=%0t", tag, act, exp, $time);
    end
  endtask

  // drives one cycle of inputs, advances the model, then checks outputs
  task automatic step(string tag);
    logic h;
    h = exp_hit(res_valid, res_data, res_chan, res_grp);
    @(posedge clk);
    #2;
    m_flag = h ? 1'b1 : (evt_clr ? 1'b0 : m_flag);
    if (cfg_off) begin
      m_single = 0; m_chan = 0; m_reg = 0; m_ins = 0;
    end else if (cfg_wr) begin
      m_lo = cfg_lo; m_hi = cfg_hi; m_single = cfg_single; m_chan = cfg_chan;
      m_reg = cfg_reg_en; m_ins = cfg_ins_en;
    end
    check({tag, " flag"}, evt_flag, m_flag);
    check("R7 irq", evt_irq, m_flag & int_en);
    check("R8 ready", res_ready, 1'b1);
    res_valid = 0; cfg_wr = 0; cfg_off = 0; evt_clr = 0;
  endtask

  task automatic load(logic [11:0] lo, logic [11:0] hi, logic s, logic [4:0] c, logic re, logic ie);
    cfg_wr = 1; cfg_lo = lo; cfg_hi = hi; cfg_single = s; cfg_chan = c;
    cfg_reg_en = re; cfg_ins_en = ie;
    step("R9 load");
  endtask

  task automatic send(string tag, logic [11:0] d, logic [4:0] c, logic g);
    res_valid = 1; res_data = d; res_chan = c; res_grp = g;
    step(tag);
  endtask

  task automatic clear();
    evt_clr = 1;
    step("R6 clear");
  endtask

  initial begin
    void'($urandom(32'd1234));
    #22;
    check("R1 flag at reset", evt_flag, 1'b0);
    check("R1 irq at reset", evt_irq, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // R1: no monitoring after reset: zero thresholds, value 4095 ignored
    send("R1 disabled", 12'd4095, 5'd0, 1'b0);
    int_en = 1;
    // R2: boundaries
    load(12'd100, 12'd200, 0, 0, 1, 1);
    send("R2 eq low", 12'd100, 5'd3, 1'b0);
    send("R2 eq high", 12'd200, 5'd3, 1'b0);
    send("R2 below low", 12'd99, 5'd3, 1'b0);
    clear();
    send("R2 above high", 12'd201, 5'd3, 1'b1);
    clear();
    // R3: regular only
    load(12'd100, 12'd200, 0, 0, 1, 0);
    send("R3 inserted ignored", 12'd4000, 5'd1, 1'b1);
    send("R3 regular watched", 12'd4000, 5'd1, 1'b0);
    clear();
    load(12'd100, 12'd200, 0, 0, 0, 1);
    send("R3 regular ignored", 12'd0, 5'd2, 1'b0);
    send("R3 inserted watched", 12'd0, 5'd2, 1'b1);
    clear();
    // R4: single channel 7, group enables off
    load(12'd100, 12'd200, 1, 5'd7, 0, 0);
    send("R4 other channel", 12'd4095, 5'd6, 1'b0);
    send("R4 selected inserted", 12'd4095, 5'd7, 1'b1);
    clear();
    send("R4 selected regular", 12'd5, 5'd7, 1'b0);
    // R6: clear together with an event keeps flag
    evt_clr = 1; res_valid = 1; res_data = 12'd4095; res_chan = 5'd7; res_grp = 0;
    step("R6 set beats clear");
    // R7: interrupt gating off
    int_en = 0;
    step("R7 gated off");
    int_en = 1;
    clear();
    // R5: off wins over write, then nothing is watched
    cfg_off = 1; cfg_wr = 1; cfg_lo = 0; cfg_hi = 0; cfg_single = 0;
    cfg_reg_en = 1; cfg_ins_en = 1;
    step("R5 off");
    send("R5 regular after off", 12'd4095, 5'd7, 1'b0);
    send("R5 inserted after off", 12'd0, 5'd7, 1'b1);
    // R5 thresholds kept: reenable groups via a write of same thresholds tested in model
    // R8: idle cycle with out-of-window data
    load(12'd100, 12'd200, 0, 0, 1, 1);
    res_valid = 0; res_data = 12'd4095;
    step("R8 idle");
    // R9: result on the load edge uses the old configuration
    cfg_wr = 1; cfg_lo = 0; cfg_hi = 12'd4095; cfg_single = 0; cfg_reg_en = 1; cfg_ins_en = 1;
    res_valid = 1; res_data = 12'd3000; res_chan = 0; res_grp = 0;
    step("R9 load edge");
    send("R9 after load", 12'd3000, 5'd0, 1'b0);
    clear();
    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8) begin
        cfg_wr = 1;
        cfg_lo = 12'($urandom_range(0, 2047)); cfg_hi = 12'($urandom_range(2048, 4095));
        cfg_single = 1'($urandom_range(0, 1)); cfg_chan = 5'($urandom_range(0, 3));
        cfg_reg_en = 1'($urandom_range(0, 1)); cfg_ins_en = 1'($urandom_range(0, 1));
      end else if (r < 10) begin
        cfg_off = 1;
      end
      if ($urandom_range(0, 9) == 0) evt_clr = 1;
      if ($urandom_range(0, 19) == 0) int_en = ~int_en;
      res_valid = 1'($urandom_range(0, 1));
      res_data = 12'($urandom_range(0, 4095));
      res_chan = 5'($urandom_range(0, 3));
      res_grp = 1'($urandom_range(0, 1));
      step("R2 R3 R4 R6 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule